// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block sits between a core's load/store path and a 32-bit data bus. It accepts one 4-byte request at a time with a byte-granular address. A request whose address has its two low bits at zero goes out as one bus operation. Any other request crosses a word boundary, so it goes out as two operations in sequence. The first covers the bytes from the original address up to the end of its word. The second covers the remaining bytes, starting at the next word-aligned address.

For stores, the block rotates the write data so that each byte lands on the lane that matches its address. For loads, it collects the lanes returned by both operations and presents a right-justified 32-bit result.

A second transfer mode serves external-control accesses. In this mode the splitting and lane steering are unchanged. The burst line and the three size lines carry a 4-bit resource identifier, which is sampled from a configuration input when the request is accepted. The block holds no lock across the two halves, so the bus is free to serve other masters between them.

Top module: `wordSplitter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busReq and reqDone are low.
- R2: A request whose reqAddr[1:0] is 00 produces exactly one operation with busAddr equal to reqAddr, size code 100 and busLanes = 8'h0F.
- R3: A request with off = reqAddr[1:0] not equal to 00 produces two operations. The first uses busAddr = reqAddr and carries 4-off bytes on lanes off..3. The second uses busAddr = {reqAddr[AW-1:2]+1, 00}, so the carry ripples into the upper bits and the address wraps at the top, and carries off bytes on lanes 0..off-1.
- R4: Size codes are 100, 011, 010 and 001 for 4, 3, 2 and 1 bytes. busLanes bit i enables lane i, and bits 7..4 are always 0.
- R5: Each operation holds busReq, busAddr and busLanes unchanged until busAck. The second operation appears only in the cycle after the first one is acknowledged.
- R6: reqDone is high for exactly one cycle, the cycle after the final busAck, and busReq is low in that cycle.
- R7: For a store, busWrite is 1, and lane i (busWdata[8i+7:8i]) carries request byte (i-off) mod 4. Request byte k, reqWdata[8k+7:8k], belongs to address reqAddr+k.
- R8: For a load, busWrite is 0. While reqDone is high, rdData[8k+7:8k] holds the byte read for address reqAddr+k, taken from whichever operation covered that address.
- R9: With reqExt set, both operations carry {busBurst, busSize} equal to the ridCfg value sampled when the request was accepted. Later changes to ridCfg have no effect on that request.
- R10: With reqExt clear, busBurst is 0 on every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present, held until reqDone |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | AW | Byte address of the 4-byte access |
| reqWdata | input | 32 | Store data, byte k for address reqAddr+k |
| reqExt | input | 1 | External-control transfer mode |
| ridCfg | input | 4 | Resource identifier for external-control mode |
| reqDone | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Right-justified load result, valid with reqDone |
| busReq | output | 1 | Bus operation request |
| busAddr | output | AW | Operation address |
| busSize | output | 3 | Size code, or low three resource-ID bits |
| busBurst | output | 1 | Burst line, or top resource-ID bit |
| busWrite | output | 1 | Operation direction |
| busLanes | output | 8 | Byte-lane enables, lanes 4..7 unused |
| busWdata | output | 32 | Lane-steered write data |
| busAck | input | 1 | Operation acknowledge |
| busRdata | input | 32 | Read data by lane |

## Verification
The assertions check, on every cycle, that:
- the upper lanes stay idle;
- an unacknowledged operation holds still;
- the second half always sits on a word-aligned address;
- in normal mode, the number of enabled lanes matches the size code and the burst line stays low;
- completion follows an acknowledge.

Only the bench scenarios can show the values themselves:
- the exact addresses, including the carry into the upper bits and the wrap at the top of the address space;
- the rotated store bytes and the merged load result for each offset;
- that ridCfg is latched at acceptance rather than followed live.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int LANE_CNT = 4;

  typedef struct packed {
    logic capture;
    logic firstAck;
    logic secondAck;
    logic inSecond;
  } stepStrb_t;

  // Transfer size code: binary byte count, 4 bytes -> 100
  function automatic logic [2:0] sizeCode(input logic [2:0] nBytes);
    logic [2:0] c;
    case (nBytes)
      3'd4:    c = 3'b100;
      3'd3:    c = 3'b011;
      3'd2:    c = 3'b010;
      default: c = 3'b001;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/splitCtrl.sv
module splitCtrl
  import splitPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      busAck,
  input  logic      isSplit,
  output stepStrb_t strb,
  output logic      busReq,
  output logic      reqDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_OP1, ST_OP2, ST_FIN} stepState_t;

  stepState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strb.capture   = 1'b0;
    strb.firstAck  = 1'b0;
    strb.secondAck = 1'b0;
    strb.inSecond  = (state == ST_OP2);
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        stateNext    = ST_OP1;
      end
      ST_OP1: if (busAck) begin
        strb.firstAck = 1'b1;
        stateNext     = isSplit ? ST_OP2 : ST_FIN;
      end
      ST_OP2: if (busAck) begin
        strb.secondAck = 1'b1;
        stateNext      = ST_FIN;
      end
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busReq  = (state == ST_OP1) || (state == ST_OP2);
  assign reqDone = (state == ST_FIN);
endmodule

// File: rtl/splitPath.sv
module splitPath
  import splitPkg::*;
#(
  parameter int AW = 32,
  parameter int BUS_LANES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepStrb_t            strb,
  input  logic [AW-1:0]        reqAddr,
  input  logic                 reqWrite,
  input  logic [31:0]          reqWdata,
  input  logic                 reqExt,
  input  logic [3:0]           ridCfg,
  input  logic [31:0]          busRdata,
  output logic                 isSplit,
  output logic                 extMode,
  output logic [AW-1:0]        busAddr,
  output logic [2:0]           busSize,
  output logic                 busBurst,
  output logic                 busWrite,
  output logic [BUS_LANES-1:0] busLanes,
  output logic [31:0]          busWdata,
  output logic [31:0]          rdData
);
  localparam int OFFW = $clog2(LANE_CNT);

  logic [AW-1:0]       addrQ;
  logic                writeQ;
  logic [31:0]         wdataQ;
  logic                extQ;
  logic [3:0]          ridQ;
  logic [7:0]          accQ [LANE_CNT];
  logic [OFFW-1:0]     off;
  logic [LANE_CNT-1:0] firstLanes;
  logic [LANE_CNT-1:0] laneSel;
  logic [2:0]          nBytes;
  logic [OFFW-1:0]     srcLane;
  logic [OFFW-1:0]     dstLane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      extQ   <= 1'b0;
      ridQ   <= '0;
    end else if (strb.capture) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      extQ   <= reqExt;
      ridQ   <= ridCfg;
    end
  end

  assign off        = addrQ[OFFW-1:0];
  assign isSplit    = (off != '0);
  assign extMode    = extQ;
  assign firstLanes = 4'b1111 << off;
  assign laneSel    = strb.inSecond ? ~firstLanes : firstLanes;
  assign nBytes     = strb.inSecond ? {1'b0, off} : (3'd4 - {1'b0, off});

  assign busAddr  = strb.inSecond ? {addrQ[AW-1:OFFW] + 1'b1, {OFFW{1'b0}}} : addrQ;
  assign busSize  = extQ ? ridQ[2:0] : sizeCode(nBytes);
  assign busBurst = extQ & ridQ[3];
  assign busWrite = writeQ;
  assign busLanes = {{(BUS_LANES-LANE_CNT){1'b0}}, laneSel};

  // store: lane i takes request byte (i - off) mod 4
  always_comb begin
    busWdata = '0;
    srcLane  = '0;
    for (int i = 0; i < LANE_CNT; i++) begin
      srcLane = OFFW'(i) - off;
      busWdata[8*i +: 8] = wdataQ[8*srcLane +: 8];
    end
  end

  // load: collect enabled lanes of each acknowledged operation
  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ[g] <= '0;
      else if ((strb.firstAck || strb.secondAck) && laneSel[g])
        accQ[g] <= busRdata[8*g +: 8];
    end
  end

  // result byte k comes from lane (k + off) mod 4
  always_comb begin
    rdData  = '0;
    dstLane = '0;
    for (int k = 0; k < LANE_CNT; k++) begin
      dstLane = OFFW'(k) + off;
      rdData[8*k +: 8] = accQ[dstLane];
    end
  end
endmodule

// File: rtl/wordSplitter.sv
module wordSplitter
  import splitPkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [31:0]   reqWdata,
  input  logic          reqExt,
  input  logic [3:0]    ridCfg,
  output logic          reqDone,
  output logic [31:0]   rdData,
  output logic          busReq,
  output logic [AW-1:0] busAddr,
  output logic [2:0]    busSize,
  output logic          busBurst,
  output logic          busWrite,
  output logic [7:0]    busLanes,
  output logic [31:0]   busWdata,
  input  logic          busAck,
  input  logic [31:0]   busRdata
);
  stepStrb_t strb;
  logic      isSplit;
  logic      extMode;
  logic      inSecond;

  splitCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck),
    .isSplit(isSplit), .strb(strb), .busReq(busReq), .reqDone(reqDone)
  );

  splitPath #(.AW(AW), .BUS_LANES(8)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqExt(reqExt),
    .ridCfg(ridCfg), .busRdata(busRdata), .isSplit(isSplit),
    .extMode(extMode), .busAddr(busAddr), .busSize(busSize),
    .busBurst(busBurst), .busWrite(busWrite), .busLanes(busLanes),
    .busWdata(busWdata), .rdData(rdData)
  );

  assign inSecond = strb.inSecond;
endmodule

// File: rtl/splitCheck.sv
module splitCheck #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busReq,
  input logic          busAck,
  input logic [AW-1:0] busAddr,
  input logic [7:0]    busLanes,
  input logic [2:0]    busSize,
  input logic          busBurst,
  input logic          reqDone,
  input logic          inSecond,
  input logic          extMode
);
  // R4
  upper_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busLanes[7:4] == 4'b0000);

  // R3
  second_half_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && inSecond) |-> busAddr[1:0] == 2'b00);

  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busLanes)));

  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqDone) |-> $past(busReq && busAck));

  // R6
  done_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> !busReq);

  // R4
  lanes_match_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !extMode) |-> ($countones(busLanes) == ((busSize == 3'b100) ? 4 : int'(busSize))));

  // R10
  burst_low_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !extMode) |-> !busBurst);
endmodule

bind wordSplitter splitCheck #(.AW(AW)) uCheck (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAck(busAck),
  .busAddr(busAddr), .busLanes(busLanes), .busSize(busSize),
  .busBurst(busBurst), .reqDone(reqDone), .inSecond(inSecond),
  .extMode(extMode)
);

// File: tb/wordSplitter_test.sv
`timescale 1ns/1ps
module wordSplitter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqExt = 1'b0;
  logic [3:0]  ridCfg = '0;
  logic        reqDone;
  logic [31:0] rdData;
  logic        busReq;
  logic [31:0] busAddr;
  logic [2:0]  busSize;
  logic        busBurst;
  logic        busWrite;
  logic [7:0]  busLanes;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wordSplitter #(.AW(32)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqExt(reqExt), .ridCfg(ridCfg),
    .reqDone(reqDone), .rdData(rdData), .busReq(busReq), .busAddr(busAddr),
    .busSize(busSize), .busBurst(busBurst), .busWrite(busWrite),
    .busLanes(busLanes), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one complete access with a bus responder; lo = word at reqAddr, hi = next word
  task automatic doAccess(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                          input logic ext, input logic [3:0] rid, input int waitCyc,
                          input logic [31:0] lo, input logic [31:0] hi);
    logic [1:0]  off;
    int          nOps;
    logic [31:0] expAddr;
    logic [3:0]  expLanes;
    logic [2:0]  expSize;
    logic [31:0] expRd;
    logic [31:0] laneMask;
    logic [31:0] expWd;
    off  = a[1:0];
    nOps = (off == 2'b00) ? 1 : 2;
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqWdata = wd; reqExt = ext; ridCfg = rid;
    reqValid = 1'b1;
    @(negedge clk);
    for (int op = 0; op < nOps; op++) begin
      expAddr  = (op == 0) ? a : {a[31:2] + 30'd1, 2'b00};
      expLanes = (op == 0) ? (4'hF << off) : ~(4'hF << off);
      if (ext) expSize = rid[2:0];
      else expSize = (op == 0) ? (3'd4 - {1'b0, off}) : {1'b0, off};
      chk(nOps == 1 ? "R2 busReq" : "R5 busReq", {31'b0, busReq}, 32'd1);
      chk(nOps == 1 ? "R2 addr" : "R3 addr", busAddr, expAddr);
      chk(nOps == 1 ? "R2 lanes" : "R4 lanes", {24'b0, busLanes}, {28'b0, expLanes});
      chk(ext ? "R9 size rid" : "R4 size code", {29'b0, busSize}, {29'b0, expSize});
      chk(ext ? "R9 burst rid" : "R10 burst", {31'b0, busBurst}, ext ? {31'b0, rid[3]} : 32'd0);
      chk(wr ? "R7 write" : "R8 write", {31'b0, busWrite}, {31'b0, wr});
      if (wr) begin
        laneMask = '0;
        expWd    = '0;
        for (int i = 0; i < 4; i++) begin
          expWd[8*i +: 8] = wd[8*((i - int'(off)) & 3) +: 8];
          if (expLanes[i]) laneMask[8*i +: 8] = 8'hFF;
        end
        chk("R7 wdata", busWdata & laneMask, expWd & laneMask);
      end
      if (ext && op == 0) ridCfg = ~rid;
      for (int w = 0; w < waitCyc; w++) begin
        @(negedge clk);
        chk("R5 hold req", {31'b0, busReq}, 32'd1);
        chk("R5 hold addr", busAddr, expAddr);
        chk("R6 no early done", {31'b0, reqDone}, 32'd0);
      end
      busRdata = (op == 0) ? lo : hi;
      busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
      busRdata = 32'hDEAD_BEEF;
    end
    chk("R6 done pulse", {31'b0, reqDone}, 32'd1);
    chk("R6 bus quiet", {31'b0, busReq}, 32'd0);
    if (!wr) begin
      for (int k = 0; k < 4; k++) begin
        if (int'(off) + k < 4) expRd[8*k +: 8] = lo[8*(int'(off) + k) +: 8];
        else expRd[8*k +: 8] = hi[8*(int'(off) + k - 4) +: 8];
      end
      chk("R8 rdData", rdData, expRd);
    end
    reqValid = 1'b0;
    ridCfg = rid;
    @(negedge clk);
    chk("R6 done one cycle", {31'b0, reqDone}, 32'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busReq in reset", {31'b0, busReq}, 32'd0);
    chk("R1 done in reset", {31'b0, reqDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busReq after reset", {31'b0, busReq}, 32'd0);
    chk("R1 done after reset", {31'b0, reqDone}, 32'd0);
  endtask

  task automatic testAligned();
    doAccess(32'h0000_1000, 1'b0, 32'h0, 1'b0, 4'h0, 0, 32'h4433_2211, 32'h0);
    doAccess(32'h0000_2004, 1'b1, 32'hA1B2_C3D4, 1'b0, 4'h0, 1, 32'h0, 32'h0);
  endtask

  task automatic testSplitOffsets();
    for (int o = 1; o < 4; o++) begin
      doAccess(32'h0000_3000 + o, 1'b0, 32'h0, 1'b0, 4'h0, 0, 32'h1312_1110, 32'h2322_2120);
      doAccess(32'h0000_4000 + o, 1'b1, 32'h8877_6655, 1'b0, 4'h0, 0, 32'h0, 32'h0);
    end
  endtask

  task automatic testCarry();
    doAccess(32'h0000_FFFF, 1'b0, 32'h0, 1'b0, 4'h0, 0, 32'hAA00_0000, 32'h00BB_CCDD);
    doAccess(32'hFFFF_FFFE, 1'b1, 32'h0102_0304, 1'b0, 4'h0, 0, 32'h0, 32'h0);
  endtask

  task automatic testExtMode();
    doAccess(32'h0000_0105, 1'b0, 32'h0, 1'b1, 4'b1010, 1, 32'h5544_3322, 32'h9988_7766);
    doAccess(32'h0000_0207, 1'b1, 32'hCAFE_F00D, 1'b1, 4'b0101, 0, 32'h0, 32'h0);
    doAccess(32'h0000_0300, 1'b0, 32'h0, 1'b1, 4'b1111, 0, 32'h1234_5678, 32'h0);
  endtask

  task automatic testWaitStates();
    doAccess(32'h0000_5006, 1'b0, 32'h0, 1'b0, 4'h0, 3, 32'hF0E0_D0C0, 32'hB0A0_9080);
    doAccess(32'h0000_5009, 1'b1, 32'h7766_5544, 1'b0, 4'h0, 2, 32'h0, 32'h0);
  endtask

  initial begin
    testReset();
    testAligned();
    testSplitOffsets();
    testCarry();
    testExtMode();
    testWaitStates();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule